// File: doc/BRIEF.md
# Burst Read Buffer with Per-Word Valid Vector

This block sits on the read path between a synchronous, pipelined memory link and an SDRAM controller. It keeps exactly one SDRAM burst of read data, the burst-aligned base address of that burst, the burst's length, and one valid flag per stored word. The result is a single-line prefetch cache. A link read whose address falls inside the stored burst, and whose word is flagged valid, is answered straight from the buffer in the request cycle.

Any other read sends one burst read command to the SDRAM controller. When the command is issued, the valid flags are cleared and the new base address is recorded. Returned words appear on the SDRAM data input a fixed number of cycles later (`LAT`), one word per cycle. Each word is written into the buffer, and its flag is set as it lands. A waiting link read is acknowledged in the very cycle its word arrives.

The write path is snooped. Any write that lands inside the stored burst drops every valid flag. If that write comes while a burst is still returning, the rest of that burst is discarded, so stale data never reaches the link. The burst length (2, 4 or 8 words) is picked at run time and takes effect at the next burst command.

Top module: `burst_rdbuf`

## Requirements
- R1: After reset no word is valid, `lk_ack` and `sd_rd_cmd` stay low while `lk_req` is low, and the first read of any address causes a burst command.
- R2: A read that cannot be served drives `sd_rd_cmd` high for exactly one cycle. `sd_rd_addr` carries the request address with its low bits cleared to the burst boundary, and `sd_rd_blen` carries `cfg_blen`. The length encoding is 0 = 2 words, 1 = 4 words, 2 or 3 = 8 words.
- R3: A read that causes a burst command in cycle t, for the word at offset j inside the burst, is acknowledged in cycle t+LAT+j. `lk_rdata` then equals the word driven on `sd_rdata` in that cycle.
- R4: A read of a valid word inside the stored burst is acknowledged in the cycle `lk_req` is raised, with the stored data, and causes no burst command.
- R5: While a burst is returning, a read of a later word of that same burst waits without a new command. It is acknowledged in the cycle that word arrives.
- R6: A read outside the stored burst while a burst is still returning issues no command until the last word has arrived. It is then handled as a new miss, starting the cycle after the last word.
- R7: `wr_vld` with a `wr_addr` inside the stored burst clears every valid flag, so the next read in that burst misses. A write outside the burst leaves hits unchanged.
- R8: A write inside the burst while it is returning discards the remaining words of that burst. A read waiting for one of them gets data from a fresh burst that is commanded after the old one ends.
- R9: `cfg_blen` sets the length and alignment of the next burst only. The stored burst keeps the length it was fetched with for its range check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_blen | input | 2 | Burst length code for the next command (0:2, 1:4, 2/3:8 words) |
| lk_req | input | 1 | Link read request, held until acknowledged |
| lk_addr | input | AW | Link word address |
| lk_ack | output | 1 | Read data valid / request completed this cycle |
| lk_rdata | output | DW | Read data, valid with `lk_ack` |
| wr_vld | input | 1 | A write to memory is taking place this cycle |
| wr_addr | input | AW | Word address of that write |
| sd_rd_cmd | output | 1 | One-cycle burst read command to the SDRAM controller |
| sd_rd_addr | output | AW | Burst-aligned start address of the command |
| sd_rd_blen | output | 2 | Length code of the command |
| sd_rdata | input | DW | Returned burst word, LAT+k cycles after the command for word k |

## Verification
The bench covers the cycle-exact wait for words at different offsets in a burst. A design that forwards one cycle late, or waits for the whole burst, shows up as a wrong wait count. It reads later words of a burst that is still arriving. A design that re-commands instead of forwarding would raise the command count. It switches the burst length between 2, 4 and 8 around a still-stored line, which catches range checks that use the live setting instead of the stored one. It also places a write inside a burst that is still arriving. The memory model there returns a value for the written word that differs from the one captured at command time, so a buffer that keeps filling after the write returns the stale word.

// File: rtl/brb_pkg.sv
`timescale 1ns/1ps
package brb_pkg;

    localparam int MAX_WORDS = 8;
    localparam int IW        = $clog2(MAX_WORDS);

    typedef enum logic [1:0] {
        BL_2  = 2'd0,
        BL_4  = 2'd1,
        BL_8  = 2'd2,
        BL_8X = 2'd3
    } blen_e;

    typedef struct packed {
        logic          wr;
        logic [IW-1:0] idx;
    } fill_t;

    function automatic logic [IW:0] burst_words(input blen_e code);
        case (code)
            BL_2:    return (IW+1)'(2);
            BL_4:    return (IW+1)'(4);
            default: return (IW+1)'(MAX_WORDS);
        endcase
    endfunction

endpackage

// File: rtl/brb_store.sv
`timescale 1ns/1ps
module brb_store
    import brb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr,
    input  logic [IW-1:0]        wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic [IW-1:0]        rd_idx,
    output logic [DW-1:0]        rd_data,
    output logic [MAX_WORDS-1:0] vld
);

    logic [DW-1:0] words_q [MAX_WORDS];

    always_ff @(posedge clk) begin
        if (wr) begin
            words_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld <= '0;
        end else if (wr) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    assign rd_data = words_q[rd_idx];

endmodule

// File: rtl/brb_fill.sv
`timescale 1ns/1ps
module brb_fill
    import brb_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  blen_e start_code,
    output logic  busy,
    output fill_t fill
);

    localparam int CW = $clog2(LAT + MAX_WORDS + 1);

    logic [CW-1:0] cnt_q;
    blen_e         code_q;
    logic          last;
    logic [CW-1:0] offs;

    always_comb begin
        offs     = cnt_q - CW'(LAT);
        fill.wr  = busy && (cnt_q >= CW'(LAT));
        fill.idx = offs[IW-1:0];
        last     = fill.wr && ((IW+1)'(fill.idx) == burst_words(code_q) - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            code_q <= BL_2;
        end else if (start) begin
            busy   <= 1'b1;
            cnt_q  <= CW'(1);
            code_q <= start_code;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    initial begin
        if (LAT < 1) $error("LAT must be at least 1");
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);  // R6

endmodule

// File: rtl/burst_rdbuf.sv
`timescale 1ns/1ps
module burst_rdbuf
    import brb_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_blen,
    input  logic          lk_req,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_ack,
    output logic [DW-1:0] lk_rdata,
    input  logic          wr_vld,
    input  logic [AW-1:0] wr_addr,
    output logic          sd_rd_cmd,
    output logic [AW-1:0] sd_rd_addr,
    output logic [1:0]    sd_rd_blen,
    input  logic [DW-1:0] sd_rdata
);

    // stored line: base, length, poison flag for an interrupted burst
    logic [AW-1:0]        base_q;
    blen_e                code_q;
    logic                 poison_q;

    logic [AW-1:0]        line_mask;
    logic [AW-1:0]        next_mask;
    logic [IW-1:0]        rd_idx;
    logic                 req_in, snp_hit, fwd, issue, busy;
    logic                 st_wr;
    logic [DW-1:0]        st_data;
    logic [MAX_WORDS-1:0] vld;
    fill_t                fill;

    function automatic logic in_line(input logic [AW-1:0] a,
                                     input logic [AW-1:0] b,
                                     input logic [AW-1:0] m);
        return ((a ^ b) & ~m) == '0;
    endfunction

    always_comb begin
        line_mask = AW'(burst_words(code_q) - 1'b1);
        next_mask = AW'(burst_words(blen_e'(cfg_blen)) - 1'b1);
        rd_idx    = lk_addr[IW-1:0] & line_mask[IW-1:0];
        req_in    = lk_req && in_line(lk_addr, base_q, line_mask);
        snp_hit   = wr_vld && in_line(wr_addr, base_q, line_mask);
        fwd       = fill.wr && !poison_q && (fill.idx == rd_idx);
        lk_ack    = req_in && (vld[rd_idx] || fwd) && !snp_hit;
        lk_rdata  = vld[rd_idx] ? st_data : sd_rdata;
        issue     = lk_req && !lk_ack && !busy && !wr_vld;
        st_wr     = fill.wr && !poison_q && !snp_hit;
    end

    assign sd_rd_cmd  = issue;
    assign sd_rd_addr = lk_addr & ~next_mask;
    assign sd_rd_blen = cfg_blen;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            code_q   <= BL_2;
            poison_q <= 1'b0;
        end else if (issue) begin
            base_q   <= sd_rd_addr;
            code_q   <= blen_e'(cfg_blen);
            poison_q <= 1'b0;
        end else if (snp_hit) begin
            poison_q <= 1'b1;
        end
    end

    brb_fill #(.LAT(LAT)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .start      (issue),
        .start_code (blen_e'(cfg_blen)),
        .busy       (busy),
        .fill       (fill)
    );

    brb_store #(.DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (issue || snp_hit),
        .wr      (st_wr),
        .wr_idx  (fill.idx),
        .wr_data (sd_rdata),
        .rd_idx  (rd_idx),
        .rd_data (st_data),
        .vld     (vld)
    );

    AST_CMD_CLEARS_LINE: assert property (@(posedge clk) disable iff (rst)
        sd_rd_cmd |=> (vld == '0));  // R2

    AST_CMD_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        sd_rd_cmd |=> !sd_rd_cmd);  // R6

    AST_NO_ACK_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
        !(lk_ack && sd_rd_cmd));  // R4

    AST_FILL_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        fill.wr |-> ((IW+1)'(fill.idx) < burst_words(code_q)));  // R3

    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (rst)
        snp_hit |=> (vld == '0));  // R7

endmodule

// File: tb/tb_burst_rdbuf.sv
`timescale 1ns/1ps
module tb_burst_rdbuf;

    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int LAT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_blen = 2'd1;
    logic          lk_req = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_ack;
    logic [DW-1:0] lk_rdata;
    logic          wr_vld = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          sd_rd_cmd;
    logic [AW-1:0] sd_rd_addr;
    logic [1:0]    sd_rd_blen;
    logic [DW-1:0] sd_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    burst_rdbuf #(.AW(AW), .DW(DW), .LAT(LAT)) dut (
        .clk(clk), .rst(rst), .cfg_blen(cfg_blen),
        .lk_req(lk_req), .lk_addr(lk_addr), .lk_ack(lk_ack), .lk_rdata(lk_rdata),
        .wr_vld(wr_vld), .wr_addr(wr_addr),
        .sd_rd_cmd(sd_rd_cmd), .sd_rd_addr(sd_rd_addr), .sd_rd_blen(sd_rd_blen),
        .sd_rdata(sd_rdata)
    );

    // memory model: per-word write version, burst snapshot taken at command
    logic [7:0]    wver [256];
    logic [7:0]    snap [8];
    logic          m_on = 1'b0;
    int            m_cnt = 0;
    int            m_n = 0;
    logic [AW-1:0] m_base = '0;
    int            n_cmd = 0;
    logic [AW-1:0] last_base = '0;
    logic [1:0]    last_code = '0;

    function automatic int code_words(input logic [1:0] c);
        return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
    endfunction

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a, input logic [7:0] v);
        return {a, 8'h00, v};
    endfunction

    initial begin
        for (int k = 0; k < 256; k++) wver[k] = 8'h00;
    end

    always @(posedge clk) begin
        if (sd_rd_cmd) begin
            m_on      <= 1'b1;
            m_cnt     <= 1;
            m_base    <= sd_rd_addr;
            m_n       <= code_words(sd_rd_blen);
            last_base <= sd_rd_addr;
            last_code <= sd_rd_blen;
            n_cmd     <= n_cmd + 1;
            for (int k = 0; k < 8; k++) snap[k] <= wver[8'(sd_rd_addr + AW'(k))];
        end else if (m_on) begin
            m_cnt <= m_cnt + 1;
            if (m_cnt >= LAT + m_n - 1) m_on <= 1'b0;
        end
    end

    always_comb begin
        int j;
        j = m_cnt - LAT;
        if (m_on && m_cnt >= LAT && j < m_n)
            sd_rdata = mem_word(m_base + AW'(j), snap[j[2:0]]);
        else
            sd_rdata = 32'hDEAD_BEEF;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_rd(input logic [1:0] bl, input logic [AW-1:0] a,
                         output logic [DW-1:0] d, output int w);
        @(negedge clk);
        cfg_blen = bl;
        lk_req   = 1'b1;
        lk_addr  = a;
        w = 0;
        d = '0;
        while (1) begin
            #1;
            if (lk_ack) begin
                d = lk_rdata;
                break;
            end
            w++;
            if (w > 200) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 lk_req = 1'b0;
    endtask

    task automatic do_wr(input logic [AW-1:0] a);
        @(negedge clk);
        wr_vld  = 1'b1;
        wr_addr = a;
        wver[a[7:0]] = wver[a[7:0]] + 8'd1;
        @(posedge clk);
        #1 wr_vld = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // {op[3:0], blen[3:0], addr[15:0], wait[7:0], cmd_base[15:0]}; op 1 = write; base FFFF = no command
    localparam int N = 14;
    localparam logic [47:0] VEC [N] = '{
        {4'd0, 4'd1, 16'h0012, 8'd6,  16'h0010},
        {4'd0, 4'd1, 16'h0013, 8'd0,  16'hFFFF},
        {4'd0, 4'd1, 16'h0010, 8'd0,  16'hFFFF},
        {4'd0, 4'd1, 16'h0014, 8'd4,  16'h0014},
        {4'd0, 4'd1, 16'h0017, 8'd2,  16'hFFFF},
        {4'd0, 4'd0, 16'h0016, 8'd0,  16'hFFFF},
        {4'd0, 4'd0, 16'h0019, 8'd5,  16'h0018},
        {4'd0, 4'd0, 16'h001A, 8'd4,  16'h001A},
        {4'd0, 4'd2, 16'h0025, 8'd10, 16'h0020},
        {4'd0, 4'd2, 16'h0021, 8'd0,  16'hFFFF},
        {4'd1, 4'd2, 16'h0030, 8'd0,  16'h0000},
        {4'd0, 4'd2, 16'h0022, 8'd0,  16'hFFFF},
        {4'd1, 4'd2, 16'h0027, 8'd0,  16'h0000},
        {4'd0, 4'd2, 16'h0022, 8'd6,  16'h0020}
    };
    localparam string TAG [N] = '{"R3", "R5", "R4", "R2", "R5", "R9", "R9",
                                  "R9", "R6", "R4", "R7", "R7", "R7", "R7"};

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (any R) actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        int            w;
        int            c0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        for (int i = 0; i < N; i++) begin
            logic [47:0] e;
            e  = VEC[i];
            c0 = n_cmd;
            if (e[47:44] == 4'd1) begin
                do_wr(e[39:24]);
            end else begin
                do_rd(e[41:40], e[39:24], d, w);
                chk({TAG[i], " wait"}, 32'(w), 32'(e[23:16]));
                chk({TAG[i], " data"}, d, mem_word(e[39:24], wver[e[31:24]]));
                if (e[15:0] == 16'hFFFF) begin
                    chk({TAG[i], " no command"}, 32'(n_cmd - c0), 32'd0);
                end else begin
                    chk("R2 command base", 32'(last_base), 32'(e[15:0]));
                    chk("R2 command length", 32'(last_code), 32'(e[41:40]));
                end
            end
        end

        // R6: out-of-line read during a running burst waits, one command each
        repeat (12) @(posedge clk);
        c0 = n_cmd;
        do_rd(2'd1, 16'h0050, d, w);
        chk("R6 first miss wait", 32'(w), 32'd4);
        do_rd(2'd1, 16'h0060, d, w);
        chk("R6 held miss wait", 32'(w), 32'd7);
        chk("R6 held miss data", d, mem_word(16'h0060, wver[8'h60]));
        chk("R6 command count", 32'(n_cmd - c0), 32'd2);

        // R8: write into a burst still arriving discards the rest of it
        repeat (12) @(posedge clk);
        do_rd(2'd1, 16'h0040, d, w);
        chk("R8 first word wait", 32'(w), 32'd4);
        do_wr(16'h0043);
        do_rd(2'd1, 16'h0043, d, w);
        chk("R8 refetch wait", 32'(w), 32'd9);
        chk("R8 fresh data", d, mem_word(16'h0043, wver[8'h43]));

        // R1: reset drops the line and quiets the outputs
        repeat (12) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 ack low in reset", 32'(lk_ack), 32'd0);
        chk("R1 command low in reset", 32'(sd_rd_cmd), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ack low after reset", 32'(lk_ack), 32'd0);
        chk("R1 command low after reset", 32'(sd_rd_cmd), 32'd0);
        c0 = n_cmd;
        do_rd(2'd1, 16'h0043, d, w);
        chk("R1 first read misses", 32'(w), 32'd7);
        chk("R1 first read command", 32'(n_cmd - c0), 32'd1);
        chk("R1 first read data", d, mem_word(16'h0043, wver[8'h43]));

        summary();
        $finish;
    end

endmodule